// File: doc/BRIEF.md
# Dual-Register Bidirectional Bus Transceiver

This block moves 8-bit data between two buses, called A and B, in either direction. Each direction owns a capture register. The A-to-B register samples the A bus, and the B-to-A register samples the B bus. For each direction a select input decides what the driven side carries. It can carry the live value of the opposite bus, or it can carry the value held in that direction's register.

Two enables decide whether each side is driven. The enable toward B is active-high and the enable toward A is active-low. Each bus appears as separate input, output and output-enable vectors. The pad ring or the surrounding fabric resolves the actual wire, so no tristate net exists inside the block.

Everything runs on one system clock. The two capture inputs are level strobes that are synchronous to that clock. A register loads on the clock edge at which its strobe is first seen high after being low. The reset input is asynchronous and active-low. Its release is synchronised to the clock. While reset is in effect, both registers are cleared and both output enables are held off.

Top module: `bus_xcvr_2reg`

## Requirements
- R1: While `rst_n` is low, both `a_oe_o` and `b_oe_o` are 0, whatever the enables are. This takes effect without waiting for a clock edge. Both registers read back as 0x00 once reset ends.
- R2: The A-to-B register loads `a_in_i` at the clock edge where `cap_ab_i` is sampled 1 after it was sampled 0 at the previous edge. A strobe that stays high does not load it again. At every other edge the register keeps its value.
- R3: The B-to-A register loads `b_in_i` under the same rule, using `cap_ba_i`.
- R4: Capture works whatever the output enables are, including isolation (`en_ab_i`=0, `en_ba_n_i`=1, where neither bus is driven).
- R5: `b_oe_o` is 1 exactly when `en_ab_i` is 1. `a_oe_o` is 1 exactly when `en_ba_n_i` is 0. Both hold only outside reset.
- R6: With `sel_ab_i`=0, `b_out_o` equals `a_in_i` in the same cycle. With `sel_ab_i`=1, it equals the A-to-B register.
- R7: With `sel_ba_i`=0, `a_out_o` equals `b_in_i` in the same cycle. With `sel_ba_i`=1, it equals the B-to-A register.
- R8: Both sides may be driven at once. With both selects at 1, the stored A data appears on B and the stored B data appears on A in the same cycle.
- R9: When B is driven live from A and the B-to-A strobe rises, the B-to-A register takes the A data present on the B wire. This loads the same byte into both registers.
- R10: When both selects are 0, both strobes may rise in the same cycle, and both registers load.
- R11: After `rst_n` rises, the output enables stay off at the first clock edge. They follow the enable inputs from the second rising edge onward.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| a_in_i | input | 8 | Value present on the A bus |
| a_out_o | output | 8 | Data to drive onto the A bus |
| a_oe_o | output | 1 | Drive enable for the A bus |
| b_in_i | input | 8 | Value present on the B bus |
| b_out_o | output | 8 | Data to drive onto the B bus |
| b_oe_o | output | 1 | Drive enable for the B bus |
| cap_ab_i | input | 1 | Capture strobe for the A-to-B register (rising level) |
| cap_ba_i | input | 1 | Capture strobe for the B-to-A register (rising level) |
| sel_ab_i | input | 1 | B-side source: 0 live A, 1 stored A-to-B register |
| sel_ba_i | input | 1 | A-side source: 0 live B, 1 stored B-to-A register |
| en_ab_i | input | 1 | Drive B when 1 |
| en_ba_n_i | input | 1 | Drive A when 0 |

## Verification
The bench holds a strobe high across several edges. A design that loads on the level instead of the rising edge would overwrite the held byte with later bus data.

The bench also captures in isolation and checks the result later through the stored path. This catches a design that gates capture with the enables.

The two enable polarities are driven in every combination. A swapped polarity would drive the wrong bus or leave the right one floating.

The bench routes live A data back onto B and captures it there, which shows the store-through path. Finally, it pulls reset low between edges to check that the enables drop at once. It then counts edges after release to confirm the two-stage synchronous return.

// File: rtl/xcvr_pkg.sv
package xcvr_pkg;
  localparam int unsigned XCVR_W_DEF        = 8;
  localparam int unsigned XCVR_RST_STG_DEF  = 2;

  typedef enum logic {
    SRC_LIVE = 1'b0,
    SRC_HELD = 1'b1
  } src_sel_e;
endpackage

// File: rtl/xcvr_rst_sync.sv
module xcvr_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] chain_d;
  logic [STAGES-1:0] chain_q;

  generate
    if (STAGES == 1) begin : g_single
      always_comb chain_d = 1'b1;
    end else begin : g_multi
      always_comb chain_d = {chain_q[STAGES-2:0], 1'b1};
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= chain_d;
  end

  assign rst_sync_n = chain_q[STAGES-1];
endmodule

// File: rtl/xcvr_cap_reg.sv
module xcvr_cap_reg #(
  parameter int unsigned W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         strobe_i,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic         strobe_q;
  logic         load;
  logic [W-1:0] data_d;
  logic [W-1:0] data_q;

  always_comb begin
    load   = strobe_i & ~strobe_q;
    data_d = d_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      strobe_q <= 1'b0;
      data_q   <= '0;
    end else begin
      strobe_q <= strobe_i;
      if (load) data_q <= data_d;
    end
  end

  assign q_o = data_q;
endmodule

// File: rtl/xcvr_path_mux.sv
module xcvr_path_mux
  import xcvr_pkg::*;
#(
  parameter int unsigned W             = 8,
  parameter bit          EN_ACTIVE_LOW = 1'b0
) (
  input  logic         rst_ok_i,
  input  logic         en_i,
  input  logic         sel_i,
  input  logic [W-1:0] live_i,
  input  logic [W-1:0] held_i,
  output logic [W-1:0] out_o,
  output logic         oe_o
);
  logic en_act;

  generate
    if (EN_ACTIVE_LOW) begin : g_low
      assign en_act = ~en_i;
    end else begin : g_high
      assign en_act = en_i;
    end
  endgenerate

  always_comb begin
    out_o = (src_sel_e'(sel_i) == SRC_HELD) ? held_i : live_i;
    oe_o  = rst_ok_i & en_act;
  end
endmodule

// File: rtl/bus_xcvr_2reg.sv
module bus_xcvr_2reg
  import xcvr_pkg::*;
#(
  parameter int unsigned W       = XCVR_W_DEF,
  parameter int unsigned RST_STG = XCVR_RST_STG_DEF
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] a_in_i,
  output logic [W-1:0] a_out_o,
  output logic         a_oe_o,
  input  logic [W-1:0] b_in_i,
  output logic [W-1:0] b_out_o,
  output logic         b_oe_o,
  input  logic         cap_ab_i,
  input  logic         cap_ba_i,
  input  logic         sel_ab_i,
  input  logic         sel_ba_i,
  input  logic         en_ab_i,
  input  logic         en_ba_n_i
);
  logic         rst_ok;
  logic [W-1:0] held_ab;
  logic [W-1:0] held_ba;

  xcvr_rst_sync #(.STAGES(RST_STG)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_ok)
  );

  xcvr_cap_reg #(.W(W)) u_reg_ab (
    .clk      (clk),
    .rst_n    (rst_ok),
    .strobe_i (cap_ab_i),
    .d_i      (a_in_i),
    .q_o      (held_ab)
  );

  xcvr_cap_reg #(.W(W)) u_reg_ba (
    .clk      (clk),
    .rst_n    (rst_ok),
    .strobe_i (cap_ba_i),
    .d_i      (b_in_i),
    .q_o      (held_ba)
  );

  xcvr_path_mux #(.W(W), .EN_ACTIVE_LOW(1'b0)) u_mux_b (
    .rst_ok_i (rst_ok),
    .en_i     (en_ab_i),
    .sel_i    (sel_ab_i),
    .live_i   (a_in_i),
    .held_i   (held_ab),
    .out_o    (b_out_o),
    .oe_o     (b_oe_o)
  );

  xcvr_path_mux #(.W(W), .EN_ACTIVE_LOW(1'b1)) u_mux_a (
    .rst_ok_i (rst_ok),
    .en_i     (en_ba_n_i),
    .sel_i    (sel_ba_i),
    .live_i   (b_in_i),
    .held_i   (held_ba),
    .out_o    (a_out_o),
    .oe_o     (a_oe_o)
  );
endmodule

// File: rtl/bus_xcvr_2reg_chk.sv
module bus_xcvr_2reg_chk #(
  parameter int unsigned W = 8
) (
  input logic         clk,
  input logic         rst_n,
  input logic [W-1:0] a_in_i,
  input logic [W-1:0] a_out_o,
  input logic         a_oe_o,
  input logic [W-1:0] b_in_i,
  input logic [W-1:0] b_out_o,
  input logic         b_oe_o,
  input logic         cap_ab_i,
  input logic         cap_ba_i,
  input logic         sel_ab_i,
  input logic         sel_ba_i,
  input logic         en_ab_i,
  input logic         en_ba_n_i
);
  AST_OE_OFF_IN_RESET: assert property (@(posedge clk) !rst_n |-> (!a_oe_o && !b_oe_o)); // R1
  AST_B_OE_POLARITY: assert property (@(posedge clk) disable iff (!rst_n) b_oe_o |-> en_ab_i); // R5
  AST_A_OE_POLARITY: assert property (@(posedge clk) disable iff (!rst_n) a_oe_o |-> !en_ba_n_i); // R5
  AST_LIVE_TO_B: assert property (@(posedge clk) disable iff (!rst_n) !sel_ab_i |-> (b_out_o == a_in_i)); // R6
  AST_LIVE_TO_A: assert property (@(posedge clk) disable iff (!rst_n) !sel_ba_i |-> (a_out_o == b_in_i)); // R7
  AST_CAPTURE_AB: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(cap_ab_i) && $past(rst_n) && $past(rst_n, 2)) |=> (!sel_ab_i || (b_out_o == $past(a_in_i)))); // R2
  AST_CAPTURE_BA: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(cap_ba_i) && $past(rst_n) && $past(rst_n, 2)) |=> (!sel_ba_i || (a_out_o == $past(b_in_i)))); // R3
  AST_HOLD_AB: assert property (@(posedge clk) disable iff (!rst_n)
    (sel_ab_i && !$rose(cap_ab_i)) |=> (!sel_ab_i || $stable(b_out_o))); // R2
  AST_HOLD_BA: assert property (@(posedge clk) disable iff (!rst_n)
    (sel_ba_i && !$rose(cap_ba_i)) |=> (!sel_ba_i || $stable(a_out_o))); // R3
endmodule

bind bus_xcvr_2reg bus_xcvr_2reg_chk #(.W(W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .a_in_i    (a_in_i),
  .a_out_o   (a_out_o),
  .a_oe_o    (a_oe_o),
  .b_in_i    (b_in_i),
  .b_out_o   (b_out_o),
  .b_oe_o    (b_oe_o),
  .cap_ab_i  (cap_ab_i),
  .cap_ba_i  (cap_ba_i),
  .sel_ab_i  (sel_ab_i),
  .sel_ba_i  (sel_ba_i),
  .en_ab_i   (en_ab_i),
  .en_ba_n_i (en_ba_n_i)
);

// File: tb/sim_bus_xcvr_2reg.sv
module sim_bus_xcvr_2reg;
  logic       clk;
  logic       rst_n;
  logic [7:0] a_in, b_in, a_out, b_out;
  logic       a_oe, b_oe;
  logic       cap_ab, cap_ba, sel_ab, sel_ba, en_ab, en_ba_n;
  int         checks = 0;
  int         errors = 0;

  bus_xcvr_2reg u0 (
    .clk(clk), .rst_n(rst_n),
    .a_in_i(a_in), .a_out_o(a_out), .a_oe_o(a_oe),
    .b_in_i(b_in), .b_out_o(b_out), .b_oe_o(b_oe),
    .cap_ab_i(cap_ab), .cap_ba_i(cap_ba),
    .sel_ab_i(sel_ab), .sel_ba_i(sel_ba),
    .en_ab_i(en_ab), .en_ba_n_i(en_ba_n)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  typedef struct packed {
    logic [7:0] a;
    logic [7:0] b;
    logic       en_ab;
    logic       en_ba_n;
    logic       sel_ab;
    logic       sel_ba;
    logic       cap_ab;
    logic       cap_ba;
    logic       x_b_oe;
    logic       x_a_oe;
    logic [7:0] x_b_out;
    logic [7:0] x_a_out;
  } row_t;

  localparam int NROWS = 9;
  localparam row_t TBL [NROWS] = '{
    // a      b     enab enban sab  sba  cab  cba  boe  aoe  bout   aout
    '{8'h11, 8'h22, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 8'h11, 8'h22}, // R5 isolation, R6 R7 live
    '{8'h3C, 8'hC3, 1'b0, 1'b1, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 8'h3C, 8'hC3}, // R10 R4 joint capture
    '{8'h55, 8'hAA, 1'b0, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 8'h3C, 8'hC3}, // R4 stored view
    '{8'h55, 8'hAA, 1'b1, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 1'b1, 1'b1, 8'h3C, 8'hC3}, // R8 both driven
    '{8'h77, 8'h88, 1'b1, 1'b1, 1'b0, 1'b1, 1'b1, 1'b0, 1'b1, 1'b0, 8'h77, 8'hC3}, // R2 load
    '{8'h99, 8'h88, 1'b1, 1'b1, 1'b1, 1'b1, 1'b1, 1'b0, 1'b1, 1'b0, 8'h77, 8'hC3}, // R2 held strobe, no reload
    '{8'h99, 8'hE1, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0, 1'b1, 1'b0, 1'b1, 8'h77, 8'hE1}, // R3 load
    '{8'h12, 8'h34, 1'b0, 1'b0, 1'b1, 1'b0, 1'b1, 1'b1, 1'b0, 1'b1, 8'h12, 8'h34}, // R2 load, R3 held, R7 live
    '{8'h12, 8'h34, 1'b1, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0, 1'b1, 1'b0, 8'h12, 8'hE1}  // R3 hold
  };

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    #2000000;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    rst_n = 1'b0; a_in = 8'h00; b_in = 8'h00;
    cap_ab = 1'b0; cap_ba = 1'b0; sel_ab = 1'b1; sel_ba = 1'b1;
    en_ab = 1'b1; en_ba_n = 1'b0;
    repeat (2) @(negedge clk);
    chk("R1 b_oe in reset", {7'd0, b_oe}, 8'h00);
    chk("R1 a_oe in reset", {7'd0, a_oe}, 8'h00);

    rst_n = 1'b1;
    @(negedge clk);
    chk("R11 b_oe after first edge", {7'd0, b_oe}, 8'h00);
    chk("R11 a_oe after first edge", {7'd0, a_oe}, 8'h00);
    @(negedge clk);
    chk("R11 b_oe after second edge", {7'd0, b_oe}, 8'h01);
    chk("R11 a_oe after second edge", {7'd0, a_oe}, 8'h01);
    chk("R1 A-to-B register cleared", b_out, 8'h00);
    chk("R1 B-to-A register cleared", a_out, 8'h00);
    @(negedge clk);

    for (int i = 0; i < NROWS; i++) begin
      a_in = TBL[i].a; b_in = TBL[i].b;
      en_ab = TBL[i].en_ab; en_ba_n = TBL[i].en_ba_n;
      sel_ab = TBL[i].sel_ab; sel_ba = TBL[i].sel_ba;
      cap_ab = TBL[i].cap_ab; cap_ba = TBL[i].cap_ba;
      @(negedge clk);
      chk($sformatf("R5 b_oe row %0d", i), {7'd0, b_oe}, {7'd0, TBL[i].x_b_oe});
      chk($sformatf("R5 a_oe row %0d", i), {7'd0, a_oe}, {7'd0, TBL[i].x_a_oe});
      chk($sformatf("R6 b_out row %0d", i), b_out, TBL[i].x_b_out);
      chk($sformatf("R7 a_out row %0d", i), a_out, TBL[i].x_a_out);
    end

    // R9: B driven live from A; the bus wire then carries A data into the B-to-A register
    a_in = 8'h5A; en_ab = 1'b1; sel_ab = 1'b0; en_ba_n = 1'b1; sel_ba = 1'b0;
    cap_ab = 1'b0; cap_ba = 1'b0;
    #1;
    b_in = b_out;
    chk("R9 B wire carries live A", b_in, 8'h5A);
    cap_ab = 1'b1;
    @(negedge clk);
    cap_ab = 1'b0; cap_ba = 1'b1;
    @(negedge clk);
    cap_ba = 1'b0; sel_ab = 1'b1; sel_ba = 1'b1; en_ba_n = 1'b0;
    a_in = 8'h00; b_in = 8'hFF;
    #1;
    chk("R9 A-to-B register holds store-through byte", b_out, 8'h5A);
    chk("R9 B-to-A register holds store-through byte", a_out, 8'h5A);
    chk("R8 both sides driven b_oe", {7'd0, b_oe}, 8'h01);
    chk("R8 both sides driven a_oe", {7'd0, a_oe}, 8'h01);

    // R1: reset asserted between edges acts at once
    @(negedge clk);
    #2;
    rst_n = 1'b0;
    #1;
    chk("R1 async b_oe off", {7'd0, b_oe}, 8'h00);
    chk("R1 async a_oe off", {7'd0, a_oe}, 8'h00);
    chk("R1 async A-to-B cleared", b_out, 8'h00);
    chk("R1 async B-to-A cleared", a_out, 8'h00);
    @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    chk("R5 enables back after release", {6'd0, a_oe, b_oe}, 8'h03);
    chk("R1 registers still clear after release", b_out | a_out, 8'h00);
    finish_run();
  end
endmodule